// File: doc/BRIEF.md
# Double-Banked Tile-to-Row Reorder Buffer

This block sits between a memory stream that delivers a matrix as square tiles and a streaming one-dimensional FFT that wants whole rows. One working set is a band of `TILE_K` matrix rows across `N_COLS` columns, which is `N_COLS/TILE_K` tiles side by side. The tiles arrive one element per cycle, each tile complete before the next and tiles from left to right. The buffer then hands the FFT the band as `TILE_K` rows in natural column order.

The FFT results come back in the same row order and are written over the band in place. They then leave tile by tile, with each tile transposed. A later pass can therefore run the column stage with exactly the same row-oriented datapath.

There are two storage banks. While one band is being filled, the other can be streamed to the FFT, collect results and drain. Every port uses a valid/ready handshake, and the input is held off whenever no bank is free.

Top module: `tile_reorder_buf`

## Requirements
- R1: After reset, `tin_ready` is 1, `rows_valid` is 0 and `tout_valid` is 0.
- R2: Input element `e` of tile `t` in a band is counted from 0, with tile-local row `e / TILE_K` and tile-local column `e % TILE_K` (the column varies fastest). It appears on `rows_data` as row `e / TILE_K`, column `t*TILE_K + e % TILE_K`. Rows go out in order 0 to `TILE_K-1`, each with columns 0 to `N_COLS-1` ascending.
- R3: No element of a band is offered on `rows_valid` before all `N_COLS*TILE_K` elements of that band have been accepted.
- R4: The `p`-th accepted result of a band (from 0) belongs to row `p / N_COLS`, column `p % N_COLS`. `res_ready` is high exactly when the band owed results has been fully loaded and has not yet returned all of its results.
- R5: A band leaves its tiles from left to right. Output index `i` within tile `t` carries the result held at row `i % TILE_K`, column `t*TILE_K + i / TILE_K`, so each tile leaves transposed.
- R6: Loading of the next band is accepted (`tin_ready` high) while the previous band is still being streamed, computed or drained, provided the band two places earlier has fully left.
- R7: `tin_ready` is low whenever the band being loaded needs a bank that still holds a band that has not fully left. Accepted input therefore never runs more than `2*N_COLS*TILE_K` elements ahead of emitted output.
- R8: While `rows_valid` or `tout_valid` is high and the matching ready is low, the valid stays high and the data is unchanged in the next cycle.
- R9: `tout_valid` is high exactly when the oldest band not yet emitted has returned all of its results. Bands leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tin_valid | input | 1 | Tile-ordered input element valid |
| tin_ready | output | 1 | Buffer can accept an input element |
| tin_data | input | DATA_W | Tile-ordered input element |
| rows_valid | output | 1 | Row-ordered element for the FFT valid |
| rows_ready | input | 1 | FFT accepts the element |
| rows_data | output | DATA_W | Row-ordered element for the FFT |
| res_valid | input | 1 | FFT result valid |
| res_ready | output | 1 | Buffer can accept a result |
| res_data | input | DATA_W | FFT result, row order |
| tout_valid | output | 1 | Transposed tile-ordered output valid |
| tout_ready | input | 1 | Downstream accepts the output element |
| tout_data | output | DATA_W | Transposed tile-ordered output element |

## Verification
A wrong address walker or a swapped bank select corrupts data at the ports within one element. A load address mistake shows on the first row streamed to the FFT. A drain address mistake shows on the second element of the first tile that leaves, because that is where transposition first moves data. Faults in the bank state or the fed flag show up as a handshake flag that differs from the band-count model. Such a flag either opens the input too early, streams a band twice, or offers output before its results are complete, and the mismatch appears in the first cycle after the transition that went wrong. Holding the output side stalled lets two bands pile up, which exposes faults in the backpressure path.

// File: rtl/trb_pkg.sv
package trb_pkg;

    // Lifecycle of one storage bank.
    typedef enum logic [1:0] {
        BANK_FREE  = 2'd0,
        BANK_PROC  = 2'd1,
        BANK_DRAIN = 2'd2
    } bank_state_e;

    // Order in which an address walker visits a band.
    typedef enum logic [1:0] {
        WALK_LINEAR   = 2'd0,
        WALK_TILE_IN  = 2'd1,
        WALK_TILE_OUT = 2'd2
    } walk_mode_e;

    typedef struct packed {
        bank_state_e st;
        logic        fed;
    } bank_status_t;

    // Row-major location of (row, column offset within tile, tile index).
    function automatic int band_addr(int row, int col_in_tile, int tile, int n_cols, int k);
        return row * n_cols + tile * k + col_in_tile;
    endfunction

endpackage

// File: rtl/trb_addr_walker.sv
module trb_addr_walker
    import trb_pkg::*;
#(
    parameter int         N_COLS = 16,
    parameter int         TILE_K = 4,
    parameter walk_mode_e MODE   = WALK_LINEAR,
    localparam int        DEPTH  = N_COLS * TILE_K,
    localparam int        AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    if (MODE == WALK_LINEAR) begin : g_lin
        logic [AW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)       cnt <= '0;
            else if (step) cnt <= last ? '0 : cnt + 1'b1;
        end
        assign addr = cnt;
        assign last = (int'(cnt) == DEPTH - 1);
    end else begin : g_tile
        localparam int TILES = N_COLS / TILE_K;
        localparam int KW    = $clog2(TILE_K);
        localparam int TW    = (TILES > 1) ? $clog2(TILES) : 1;

        logic [KW-1:0] inner;
        logic [KW-1:0] outer;
        logic [TW-1:0] tile;
        logic inner_last, outer_last, tile_last;

        assign inner_last = (int'(inner) == TILE_K - 1);
        assign outer_last = (int'(outer) == TILE_K - 1);
        assign tile_last  = (int'(tile)  == TILES - 1);
        assign last       = inner_last && outer_last && tile_last;

        always_ff @(posedge clk) begin
            if (rst) begin
                inner <= '0;
                outer <= '0;
                tile  <= '0;
            end else if (step) begin
                inner <= inner_last ? '0 : inner + 1'b1;
                if (inner_last) begin
                    outer <= outer_last ? '0 : outer + 1'b1;
                    if (outer_last) tile <= tile_last ? '0 : tile + 1'b1;
                end
            end
        end

        if (MODE == WALK_TILE_IN) begin : g_in
            // tile-local row = outer, tile-local column = inner
            assign addr = AW'(band_addr(int'(outer), int'(inner), int'(tile), N_COLS, TILE_K));
        end else begin : g_out
            // emitted (outer, inner) reads stored row inner, column offset outer
            assign addr = AW'(band_addr(int'(inner), int'(outer), int'(tile), N_COLS, TILE_K));
        end
    end

endmodule

// File: rtl/trb_bank.sv
module trb_bank #(
    parameter int  DEPTH  = 64,
    parameter int  DATA_W = 128,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tile_reorder_buf.sv
module tile_reorder_buf
    import trb_pkg::*;
#(
    parameter int N_COLS = 16,
    parameter int TILE_K = 4,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tin_valid,
    output logic              tin_ready,
    input  logic [DATA_W-1:0] tin_data,
    output logic              rows_valid,
    input  logic              rows_ready,
    output logic [DATA_W-1:0] rows_data,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [DATA_W-1:0] res_data,
    output logic              tout_valid,
    input  logic              tout_ready,
    output logic [DATA_W-1:0] tout_data
);

    localparam int DEPTH  = N_COLS * TILE_K;
    localparam int AW     = $clog2(DEPTH);
    localparam int NBANKS = 2;

    bank_status_t stat [NBANKS];
    logic ld_sel, feed_sel, res_sel, dr_sel;

    logic ld_fire, feed_fire, res_fire, dr_fire;
    logic ld_last, feed_last, res_last, dr_last;
    logic [AW-1:0] ld_addr, feed_addr, res_addr, dr_addr;

    logic [DATA_W-1:0] rd_feed  [NBANKS];
    logic [DATA_W-1:0] rd_drain [NBANKS];

    // Handshake decode from the state of the bank each engine points at.
    assign tin_ready  = (stat[ld_sel].st == BANK_FREE);
    assign rows_valid = (stat[feed_sel].st == BANK_PROC) && !stat[feed_sel].fed;
    assign res_ready  = (stat[res_sel].st == BANK_PROC);
    assign tout_valid = (stat[dr_sel].st == BANK_DRAIN);

    assign ld_fire   = tin_valid  && tin_ready;
    assign feed_fire = rows_valid && rows_ready;
    assign res_fire  = res_valid  && res_ready;
    assign dr_fire   = tout_valid && tout_ready;

    trb_addr_walker #(.N_COLS(N_COLS), .TILE_K(TILE_K), .MODE(WALK_TILE_IN)) i_ld_walk (
        .clk(clk), .rst(rst), .step(ld_fire), .addr(ld_addr), .last(ld_last));

    trb_addr_walker #(.N_COLS(N_COLS), .TILE_K(TILE_K), .MODE(WALK_LINEAR)) i_feed_walk (
        .clk(clk), .rst(rst), .step(feed_fire), .addr(feed_addr), .last(feed_last));

    trb_addr_walker #(.N_COLS(N_COLS), .TILE_K(TILE_K), .MODE(WALK_LINEAR)) i_res_walk (
        .clk(clk), .rst(rst), .step(res_fire), .addr(res_addr), .last(res_last));

    trb_addr_walker #(.N_COLS(N_COLS), .TILE_K(TILE_K), .MODE(WALK_TILE_OUT)) i_dr_walk (
        .clk(clk), .rst(rst), .step(dr_fire), .addr(dr_addr), .last(dr_last));

    // Bank lifecycle: FREE -(load done)-> PROC -(results done)-> DRAIN -(drained)-> FREE.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANKS; b++) begin
                stat[b].st  <= BANK_FREE;
                stat[b].fed <= 1'b0;
            end
        end else begin
            for (int b = 0; b < NBANKS; b++) begin
                if (ld_fire && ld_last && ld_sel == 1'(b)) begin
                    stat[b].st  <= BANK_PROC;
                    stat[b].fed <= 1'b0;
                end
                if (feed_fire && feed_last && feed_sel == 1'(b)) stat[b].fed <= 1'b1;
                if (res_fire && res_last && res_sel == 1'(b))   stat[b].st  <= BANK_DRAIN;
                if (dr_fire && dr_last && dr_sel == 1'(b))      stat[b].st  <= BANK_FREE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_sel   <= 1'b0;
            feed_sel <= 1'b0;
            res_sel  <= 1'b0;
            dr_sel   <= 1'b0;
        end else begin
            ld_sel   <= ld_sel   ^ (ld_fire   && ld_last);
            feed_sel <= feed_sel ^ (feed_fire && feed_last);
            res_sel  <= res_sel  ^ (res_fire  && res_last);
            dr_sel   <= dr_sel   ^ (dr_fire   && dr_last);
        end
    end

    // Loader and result collector never target the same bank.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic              we;
        logic [AW-1:0]     wa;
        logic [DATA_W-1:0] wd;

        always_comb begin
            we = 1'b0;
            wa = ld_addr;
            wd = tin_data;
            if (ld_fire && ld_sel == 1'(b)) begin
                we = 1'b1;
            end else if (res_fire && res_sel == 1'(b)) begin
                we = 1'b1;
                wa = res_addr;
                wd = res_data;
            end
        end

        trb_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_bank (
            .clk(clk), .we(we), .waddr(wa), .wdata(wd),
            .raddr_a(feed_addr), .rdata_a(rd_feed[b]),
            .raddr_b(dr_addr),   .rdata_b(rd_drain[b]));
    end

    assign rows_data = rd_feed[feed_sel];
    assign tout_data = rd_drain[dr_sel];

endmodule

// File: rtl/trb_checker.sv
module trb_checker #(
    parameter int N_COLS = 16,
    parameter int TILE_K = 4,
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              tin_valid,
    input logic              tin_ready,
    input logic              rows_valid,
    input logic              rows_ready,
    input logic [DATA_W-1:0] rows_data,
    input logic              tout_valid,
    input logic              tout_ready,
    input logic [DATA_W-1:0] tout_data
);

    localparam int DEPTH = N_COLS * TILE_K;

    int in_cnt, fed_cnt, out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= 0;
            fed_cnt <= 0;
            out_cnt <= 0;
        end else begin
            if (tin_valid && tin_ready)   in_cnt  <= in_cnt + 1;
            if (rows_valid && rows_ready) fed_cnt <= fed_cnt + 1;
            if (tout_valid && tout_ready) out_cnt <= out_cnt + 1;
        end
    end

    // R3
    feed_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        rows_valid |-> in_cnt >= (fed_cnt / DEPTH + 1) * DEPTH);

    // R7
    bounded_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (tin_valid && tin_ready) |-> (in_cnt - out_cnt) < 2 * DEPTH);

    // R9
    emit_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        tout_valid |-> out_cnt < in_cnt);

    // R8
    rows_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rows_valid && !rows_ready) |=> (rows_valid && $stable(rows_data)));

    // R8
    tout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tout_valid && !tout_ready) |=> (tout_valid && $stable(tout_data)));

endmodule

bind tile_reorder_buf trb_checker #(.N_COLS(N_COLS), .TILE_K(TILE_K), .DATA_W(DATA_W)) i_trb_checker (
    .clk(clk), .rst(rst),
    .tin_valid(tin_valid), .tin_ready(tin_ready),
    .rows_valid(rows_valid), .rows_ready(rows_ready), .rows_data(rows_data),
    .tout_valid(tout_valid), .tout_ready(tout_ready), .tout_data(tout_data));

// File: tb/test_tile_reorder_buf.sv
module test_tile_reorder_buf;

    localparam int N     = 16;
    localparam int K     = 4;
    localparam int DW    = 128;
    localparam int NK    = N * K;
    localparam int SETS  = 8;
    localparam int TOTAL = SETS * NK;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tin_valid = 1'b0, tin_ready;
    logic [DW-1:0] tin_data = '0;
    logic rows_valid, rows_ready = 1'b0;
    logic [DW-1:0] rows_data;
    logic res_valid = 1'b0, res_ready;
    logic [DW-1:0] res_data = '0;
    logic tout_valid, tout_ready = 1'b0;
    logic [DW-1:0] tout_data;

    always #2 clk = ~clk;

    tile_reorder_buf #(.N_COLS(N), .TILE_K(K), .DATA_W(DW)) i_tile_reorder_buf (
        .clk(clk), .rst(rst),
        .tin_valid(tin_valid), .tin_ready(tin_ready), .tin_data(tin_data),
        .rows_valid(rows_valid), .rows_ready(rows_ready), .rows_data(rows_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .tout_valid(tout_valid), .tout_ready(tout_ready), .tout_data(tout_data));

    int checks = 0;
    int failures = 0;

    function automatic logic [DW-1:0] elem_val(int g);
        return {32'(g), 32'(g) ^ 32'hC3C3_0000, 32'(g * 5), 32'hFACE_0000 + 32'(g)};
    endfunction

    // Value expected at FFT-side position p of band s (R2).
    function automatic logic [DW-1:0] exp_row_val(int s, int p);
        int row = p / N;
        int col = p % N;
        int t   = col / K;
        int c   = col % K;
        return elem_val(s * NK + t * K * K + row * K + c);
    endfunction

    // Value expected at output index j of band s (R5); the FFT stand-in inverts.
    function automatic logic [DW-1:0] exp_out_val(int s, int j);
        int t = j / (K * K);
        int a = (j / K) % K;
        int b = j % K;
        return ~exp_row_val(s, b * N + t * K + a);
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_data(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    logic [DW-1:0] fq [$];
    int ld_total = 0, fed_total = 0, res_total = 0, out_total = 0;

    initial begin
        int cyc = 0;
        logic rows_hold = 1'b0, tout_hold = 1'b0;
        logic [DW-1:0] rows_prev = '0, tout_prev = '0;
        logic exp_tin, exp_rows, exp_res, exp_tout;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check_bit("R1 tin_ready", tin_ready, 1'b1);
        check_bit("R1 rows_valid", rows_valid, 1'b0);
        check_bit("R1 tout_valid", tout_valid, 1'b0);

        while (out_total < TOTAL) begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                checks++;
                failures++;
                $display("FAIL watchdog: actual=%0d expected=%0d emitted elements", out_total, TOTAL);
                break;
            end

            exp_tin  = (ld_total / NK) < (out_total / NK + 2);
            exp_rows = (fed_total < TOTAL) && (ld_total >= (fed_total / NK + 1) * NK);
            exp_res  = (res_total < TOTAL) && (ld_total >= (res_total / NK + 1) * NK);
            exp_tout = (out_total < TOTAL) && (res_total >= (out_total / NK + 1) * NK);
            check_bit(exp_tin ? "R6 tin_ready" : "R7 tin_ready", tin_ready, exp_tin);
            check_bit("R3 rows_valid", rows_valid, exp_rows);
            check_bit("R4 res_ready", res_ready, exp_res);
            check_bit("R9 tout_valid", tout_valid, exp_tout);
            if (rows_hold) check_data("R8 rows_data hold", rows_data, rows_prev);
            if (tout_hold) check_data("R8 tout_data hold", tout_data, tout_prev);

            // Stimulus: free-flowing start, then a long output stall, then random gating.
            tin_valid  = (ld_total < TOTAL) && ((cyc < 500) || ($urandom % 4 != 0));
            tin_data   = elem_val(ld_total);
            rows_ready = (cyc < 500) || ($urandom % 3 != 0);
            res_valid  = (fq.size() > 0) && ((cyc < 500) || ($urandom % 4 != 0));
            res_data   = (fq.size() > 0) ? fq[0] : '0;
            tout_ready = !(cyc >= 150 && cyc < 500) && ((cyc < 500) || ($urandom % 3 != 0));
            #1;

            rows_hold = rows_valid && !rows_ready;
            tout_hold = tout_valid && !tout_ready;
            rows_prev = rows_data;
            tout_prev = tout_data;

            if (tin_valid && tin_ready) ld_total++;
            if (rows_valid && rows_ready) begin
                check_data("R2 rows_data", rows_data, exp_row_val(fed_total / NK, fed_total % NK));
                fq.push_back(~rows_data);
                fed_total++;
            end
            if (res_valid && res_ready) begin
                void'(fq.pop_front());
                res_total++;
            end
            if (tout_valid && tout_ready) begin
                check_data("R5 tout_data", tout_data, exp_out_val(out_total / NK, out_total % NK));
                out_total++;
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule